// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a small 32-bit register bus. Software fills a four-word transmit queue, picks a word length of 1 to 32 bits, the clock idle level, the data phase and one of four select lines, then writes a start command. The shift engine sends one word from the transmit queue, most significant bit first. At the same time it collects the same number of bits from the serial input and pushes them into a four-word receive queue. A finished word raises a sticky ready flag. Queue misuse raises sticky error flags. Writing a one to any of these flags clears it.

Chip select has two modes. In software mode one command bit drives the selected line directly. In hardware mode the selected line goes low for the length of each word, and can optionally stay low between words. The serial clock runs at the system clock divided by `CLK_DIV`.

The shift engine is a three-state machine. `SH_IDLE` moves to `SH_RUN` on an accepted start. `SH_RUN` counts half-periods and moves to `SH_DONE` after the last of the 2·N clock edges. `SH_DONE` delivers the received word for one cycle and returns to `SH_IDLE`.

Register offsets (byte address): command 0x000, command2 0x004, status 0x008, queue levels 0x01C, transmit window 0x100, receive window 0x180.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, status reads 0x00A00000 (receive-empty bit 23 and transmit-empty bit 21 set, all else 0), every select line is high and the serial clock is low.
- R2: A write to command with bit 31 (enable) and bit 30 (start) both set shifts one word of N bits, where N is command bits 4:0 of that write plus one. The word is taken from the transmit queue head and sent MSB first, and its bits above N are not sent. The N received bits are pushed into the receive queue, right-aligned with zeros above.
- R3: Status bit 31 (busy) is high from the start until the word completes. At completion busy falls and status bit 30 (ready) is set.
- R4: Status bits 30, 25, 24, 19 and 18 are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. Bit 29 is the OR of bits 25, 24, 19 and 18.
- R5: Command bit 24 sets the idle serial clock level. With command bit 21 clear, data is sampled on the leading edge; with it set, data is sampled on the trailing edge.
- R6: With command bit 11 set, command bit 12 = 1 drives low the select line chosen by command2 bits 19:18, and 0 returns it high. No more than one line is ever low.
- R7: With command bit 11 clear, the chosen select line is low while busy. If command2 bit 17 is set, the line stays low after the word ends until bit 17 is cleared.
- R8: A write to the transmit window when the transmit queue is full (4 words) is dropped and sets status bit 19. Status bit 20 shows full, and the levels register bits 2:0 give the transmit count.
- R9: A read of the receive window when the receive queue is empty returns 0 and sets status bit 18. The levels register bits 18:16 give the receive count.
- R10: A start is ignored when the enable bit of the same write is clear or when busy is high. An ignored start pops nothing and shifts nothing.
- R11: A word that completes while the receive queue is full is dropped and sets status bit 25. The queue keeps its oldest words.
- R12: A start with transmit enabled (command2 bit 30) and an empty transmit queue sets status bit 24 and shifts zeros.
- R13: Writing 1 to status bit 26 empties the transmit queue, and writing 1 to status bit 27 empties the receive queue.
- R14: With command2 bit 30 clear, a start shifts zeros and does not pop the transmit queue. With command2 bit 31 clear, the received word is not pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at 0x180) |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low select lines |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `CLK_DIV` = 6. With a depth of four, both queues can be filled to the point where overflow sets in within a handful of bus writes or transfers. The divider of six gives a three-cycle half period, so a bus read can observe busy and the select lines in the middle of a word. At that divider even a 32-bit word finishes in under two hundred cycles. The serial side uses an inverting loopback: each received word is the complement of the sent one, which exposes errors in bit order, length and phase. A capture model also samples the serial output on the edge each mode calls for.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int SEL_W = 2;
    localparam int NCS   = 1 << SEL_W;

    localparam logic [8:0] A_CTRL  = 9'h000;
    localparam logic [8:0] A_CTRL2 = 9'h004;
    localparam logic [8:0] A_STAT  = 9'h008;
    localparam logic [8:0] A_LEVEL = 9'h01C;
    localparam logic [8:0] A_TXWIN = 9'h100;
    localparam logic [8:0] A_RXWIN = 9'h180;

    localparam int C_EN    = 31;
    localparam int C_GO    = 30;
    localparam int C_IDLE  = 24;
    localparam int C_PHASE = 21;
    localparam int C_CSVAL = 12;
    localparam int C_CSSW  = 11;
    localparam int C2_RXEN = 31;
    localparam int C2_TXEN = 30;
    localparam int C2_SEL  = 18;
    localparam int C2_HOLD = 17;

    localparam int S_BUSY  = 31;
    localparam int S_RDY   = 30;
    localparam int S_ERR   = 29;
    localparam int S_RXFL  = 27;
    localparam int S_TXFL  = 26;
    localparam int S_RXOVF = 25;
    localparam int S_TXUNR = 24;
    localparam int S_RXEMP = 23;
    localparam int S_RXFUL = 22;
    localparam int S_TXEMP = 21;
    localparam int S_TXFUL = 20;
    localparam int S_TXOVF = 19;
    localparam int S_RXUNR = 18;

    localparam logic [31:0] CTRL_KEEP  = 32'h9320_181F;
    localparam logic [31:0] CTRL2_KEEP = 32'hC00E_0000;

    typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_DONE} sh_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   push,
    input  logic [W-1:0]           wdata,
    input  logic                   pop,
    output logic [W-1:0]           rdata,
    output logic [$clog2(DEPTH):0] count,
    output logic                   full,
    output logic                   empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= bump(wp);
            if (pop_ok)  rp <= bump(rp);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= wdata;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift import spim_pkg::*; #(
    parameter int CLK_DIV = 4,
    parameter int WMAX    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [WMAX-1:0]         word,
    input  logic [$clog2(WMAX)-1:0] len_m1,
    input  logic                    late_phase,
    input  logic                    idle_hi,
    input  logic                    miso,
    output logic                    busy,
    output logic                    done,
    output logic [WMAX-1:0]         rx_word,
    output logic                    sclk,
    output logic                    mosi
);
    localparam int LW   = $clog2(WMAX);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int DCW  = (HALF > 1) ? $clog2(HALF) : 1;

    sh_state_t     state, nxt;
    logic [DCW-1:0] div_cnt;
    logic [LW:0]    edge_idx, last_idx;
    logic [WMAX-1:0] txsh, rxsh;
    logic           lvl, ph;
    logic           tick, leading, smp, shf;

    assign tick    = (state == SH_RUN) && (div_cnt == DCW'(HALF - 1));
    assign leading = ~edge_idx[0];
    assign smp     = leading ^ ph;
    assign shf     = ph ? (leading && edge_idx != '0) : !leading;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            SH_IDLE: if (go) nxt = SH_RUN;
            SH_RUN: begin
                busy = 1'b1;
                if (tick && edge_idx == last_idx) nxt = SH_DONE;
            end
            SH_DONE: begin
                busy = 1'b1;
                done = 1'b1;
                nxt  = SH_IDLE;
            end
            default: nxt = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            edge_idx <= '0;
            last_idx <= '0;
            txsh     <= '0;
            rxsh     <= '0;
            lvl      <= 1'b0;
            ph       <= 1'b0;
        end else if (state == SH_IDLE && go) begin
            txsh     <= word << (LW'(WMAX - 1) - len_m1);
            rxsh     <= '0;
            div_cnt  <= '0;
            edge_idx <= '0;
            lvl      <= 1'b0;
            last_idx <= {len_m1, 1'b1};
            ph       <= late_phase;
        end else if (state == SH_RUN) begin
            if (tick) begin
                div_cnt  <= '0;
                lvl      <= ~lvl;
                edge_idx <= edge_idx + 1'b1;
                if (smp) rxsh <= {rxsh[WMAX-2:0], miso};
                if (shf) txsh <= txsh << 1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign rx_word = rxsh;
    assign mosi    = txsh[WMAX-1];
    assign sclk    = idle_hi ^ lvl;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl import spim_pkg::*; #(
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [8:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [31:0] ctrl_q, ctrl2_q;
    logic        rdy_q, rx_ovf_q, tx_unr_q, tx_ovf_q, rx_unr_q, held_q;
    logic        wr_ctrl, wr_ctrl2, wr_stat, wr_tx, rd_rx;
    logic        go, tx_pop, rx_push, sh_busy, sh_done, cs_on, cfg_idle_hi;
    logic [31:0] tx_head, rx_head, sh_word, sh_rx, stat_word, level_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic        tx_full, tx_empty, rx_full, rx_empty;

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign wr_ctrl2 = bus_wr && bus_addr == A_CTRL2;
    assign wr_stat  = bus_wr && bus_addr == A_STAT;
    assign wr_tx    = bus_wr && bus_addr == A_TXWIN;
    assign rd_rx    = bus_rd && bus_addr == A_RXWIN;

    assign go      = wr_ctrl && bus_wdata[C_EN] && bus_wdata[C_GO] && !sh_busy;
    assign tx_pop  = go && ctrl2_q[C2_TXEN] && !tx_empty;
    assign sh_word = tx_pop ? tx_head : '0;
    assign rx_push = sh_done && ctrl2_q[C2_RXEN];
    assign cfg_idle_hi = ctrl_q[C_IDLE];

    spim_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(wr_stat && bus_wdata[S_TXFL]),
        .push(wr_tx), .wdata(bus_wdata), .pop(tx_pop), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    spim_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(wr_stat && bus_wdata[S_RXFL]),
        .push(rx_push), .wdata(sh_rx), .pop(rd_rx), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    spim_shift #(.CLK_DIV(CLK_DIV), .WMAX(32)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .word(sh_word),
        .len_m1(bus_wdata[4:0]), .late_phase(bus_wdata[C_PHASE]),
        .idle_hi(cfg_idle_hi), .miso(spi_miso), .busy(sh_busy),
        .done(sh_done), .rx_word(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ctrl2_q  <= '0;
            rdy_q    <= 1'b0;
            rx_ovf_q <= 1'b0;
            tx_unr_q <= 1'b0;
            tx_ovf_q <= 1'b0;
            rx_unr_q <= 1'b0;
            held_q   <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= bus_wdata & CTRL_KEEP;
            if (wr_ctrl2) ctrl2_q <= bus_wdata & CTRL2_KEEP;
            rdy_q    <= sh_done | (rdy_q & ~(wr_stat & bus_wdata[S_RDY]));
            rx_ovf_q <= (rx_push && rx_full) | (rx_ovf_q & ~(wr_stat & bus_wdata[S_RXOVF]));
            tx_unr_q <= (go && ctrl2_q[C2_TXEN] && tx_empty)
                      | (tx_unr_q & ~(wr_stat & bus_wdata[S_TXUNR]));
            tx_ovf_q <= (wr_tx && tx_full) | (tx_ovf_q & ~(wr_stat & bus_wdata[S_TXOVF]));
            rx_unr_q <= (rd_rx && rx_empty) | (rx_unr_q & ~(wr_stat & bus_wdata[S_RXUNR]));
            if (!ctrl2_q[C2_HOLD] || ctrl_q[C_CSSW]) held_q <= 1'b0;
            else if (sh_done)                       held_q <= 1'b1;
        end
    end

    assign cs_on = ctrl_q[C_CSSW] ? ctrl_q[C_CSVAL] : (sh_busy | held_q);

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign spi_cs_n[i] = ~(cs_on && ctrl2_q[C2_SEL +: SEL_W] == SEL_W'(i));
    end

    always_comb begin
        stat_word          = '0;
        stat_word[S_BUSY]  = sh_busy;
        stat_word[S_RDY]   = rdy_q;
        stat_word[S_ERR]   = rx_ovf_q | tx_unr_q | tx_ovf_q | rx_unr_q;
        stat_word[S_RXOVF] = rx_ovf_q;
        stat_word[S_TXUNR] = tx_unr_q;
        stat_word[S_RXEMP] = rx_empty;
        stat_word[S_RXFUL] = rx_full;
        stat_word[S_TXEMP] = tx_empty;
        stat_word[S_TXFUL] = tx_full;
        stat_word[S_TXOVF] = tx_ovf_q;
        stat_word[S_RXUNR] = rx_unr_q;
        level_word         = '0;
        level_word[16 +: CW] = rx_cnt;
        level_word[0 +: CW]  = tx_cnt;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_CTRL2: bus_rdata = ctrl2_q;
            A_STAT:  bus_rdata = stat_word;
            A_LEVEL: bus_rdata = level_word;
            A_RXWIN: bus_rdata = rx_empty ? '0 : rx_head;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk import spim_pkg::*; (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [8:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    bus_rdata,
    input logic           spi_sclk,
    input logic [NCS-1:0] spi_cs_n,
    input logic           busy,
    input logic           idle_hi,
    input logic           rdy,
    input logic           tx_full,
    input logic           rx_empty,
    input logic           tx_ovf
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1); // R6
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_sclk == idle_hi); // R5
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rdy); // R3
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && !(bus_wr && bus_addr == A_STAT && bus_wdata[S_RDY]) |=> rdy); // R4
    AST_START_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[C_EN] && bus_wdata[C_GO])); // R10
    AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_TXWIN && tx_full |=> tx_ovf); // R8
    AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == A_RXWIN && rx_empty |-> bus_rdata == 32'h0); // R9
endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .busy(sh_busy),
    .idle_hi(cfg_idle_hi), .rdy(rdy_q), .tx_full(tx_full),
    .rx_empty(rx_empty), .tx_ovf(tx_ovf_q));

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;
    int          n_vec = 0, n_bad = 0;
    logic [31:0] cap = '0;
    logic        m_idle = 1'b0, m_ph = 1'b0;

    localparam logic [8:0] CTRL = 9'h000, CTRL2 = 9'h004, STAT = 9'h008,
                           LVL = 9'h01C, TXW = 9'h100, RXW = 9'h180;

    always #4 clk = ~clk;

    spim_ctrl #(.FIFO_DEPTH(4), .CLK_DIV(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n));

    // inverting loopback device
    assign spi_miso = ~spi_mosi;

    // capture model: samples the serial output on the edge the mode calls for
    always @(spi_sclk) begin
        if (spi_sclk !== 1'bx && ((spi_sclk != m_idle) ^ m_ph))
            cap = {cap[30:0], spi_mosi};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(STAT, s);
            if (!s[31]) break;
        end
    endtask

    task automatic cleanup();
        wr(STAT, 32'hFFFF_FFFF);
        wr(CTRL2, 32'hC000_0000);
        wr(CTRL, 32'h9000_0007);
        m_idle = 1'b0; m_ph = 1'b0;
    endtask

    task automatic xfer(input logic [31:0] ctl, input logic [31:0] d);
        wr(TXW, d);
        wr(CTRL, ctl | 32'h4000_0000);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rd(STAT, s);
        chk("R1 status", s, 32'h00A0_0000);
        chk("R1 cs_n", {28'h0, spi_cs_n}, 32'hF);
        chk("R1 sclk", {31'h0, spi_sclk}, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] s;
        cleanup();
        wr(CTRL2, 32'hC004_0000);
        wr(TXW, 32'h0000_00A5);
        wr(CTRL, 32'hD000_0007);
        rd(STAT, s);
        chk("R3 busy", {31'h0, s[31]}, 32'h1);
        wait_idle();
        rd(STAT, s);
        chk("R3 done status", s, 32'h4020_0000);
        chk("R2 msb-first out", cap & 32'hFF, 32'hA5);
        rd(RXW, s);
        chk("R2 rx word", s, 32'h5A);
        wr(STAT, 32'h0);
        rd(STAT, s);
        chk("R4 write 0 keeps", s, 32'h40A0_0000);
        wr(STAT, 32'h4000_0000);
        rd(STAT, s);
        chk("R4 w1c ready", s, 32'h00A0_0000);
    endtask

    task automatic t_len();
        logic [31:0] s;
        cleanup();
        xfer(32'h9000_000C, 32'hFFFF_1ABC);
        chk("R2 13-bit out", cap & 32'h1FFF, 32'h1ABC);
        rd(RXW, s);
        chk("R2 13-bit in", s, 32'h0543);
        xfer(32'h9000_001F, 32'h8000_0001);
        chk("R2 32-bit out", cap, 32'h8000_0001);
        rd(RXW, s);
        chk("R2 32-bit in", s, 32'h7FFF_FFFE);
        xfer(32'h9000_0000, 32'h0000_0001);
        chk("R2 1-bit out", cap & 32'h1, 32'h1);
        rd(RXW, s);
        chk("R2 1-bit in", s, 32'h0);
    endtask

    task automatic t_modes();
        logic [31:0] s, ctl, d;
        for (int m = 0; m < 4; m++) begin
            cleanup();
            ctl = 32'h9000_0007 | (32'(m[1]) << 24) | (32'(m[0]) << 21);
            wr(CTRL, ctl);
            m_idle = m[1]; m_ph = m[0];
            chk("R5 idle level", {31'h0, spi_sclk}, {31'h0, m[1]});
            d = 32'hC3 ^ 32'(m);
            xfer(ctl, d);
            chk("R5 mode capture", cap & 32'hFF, d);
            rd(RXW, s);
            chk("R5 mode rx", s, ~d & 32'hFF);
        end
    endtask

    task automatic t_softcs();
        cleanup();
        wr(CTRL2, 32'hC008_0000);
        wr(CTRL, 32'h8000_1800);
        chk("R6 soft cs low", {28'h0, spi_cs_n}, 32'hB);
        wr(CTRL, 32'h8000_0800);
        chk("R6 soft cs high", {28'h0, spi_cs_n}, 32'hF);
    endtask

    task automatic t_hwcs();
        cleanup();
        wr(CTRL2, 32'hC00C_0000);
        wr(TXW, 32'h1);
        wr(CTRL, 32'hD000_001F);
        chk("R7 hw cs during word", {28'h0, spi_cs_n}, 32'h7);
        wait_idle();
        chk("R7 hw cs after word", {28'h0, spi_cs_n}, 32'hF);
        wr(CTRL2, 32'hC00E_0000);
        xfer(32'h9000_0007, 32'h2);
        chk("R7 hold keeps cs", {28'h0, spi_cs_n}, 32'h7);
        wr(CTRL2, 32'hC00C_0000);
        @(negedge clk);
        chk("R7 hold release", {28'h0, spi_cs_n}, 32'hF);
    endtask

    task automatic t_txovf();
        logic [31:0] s;
        cleanup();
        for (int i = 0; i < 5; i++) wr(TXW, 32'(i + 1));
        rd(STAT, s);
        chk("R8 tx overflow status", s, 32'h2098_0000);
        rd(LVL, s);
        chk("R8 tx count", s, 32'h4);
        wr(STAT, 32'h0400_0000);
        rd(LVL, s);
        chk("R13 tx flush", s, 32'h0);
        rd(STAT, s);
        chk("R13 flush keeps flags", s, 32'h20A8_0000);
    endtask

    task automatic t_rxunr();
        logic [31:0] s;
        cleanup();
        rd(RXW, s);
        chk("R9 empty read", s, 32'h0);
        rd(STAT, s);
        chk("R9 rx underrun", s, 32'h20A4_0000);
    endtask

    task automatic t_ignore();
        logic [31:0] s;
        cleanup();
        wr(TXW, 32'h11);
        wr(CTRL, 32'h4000_0007);
        rd(STAT, s);
        chk("R10 disabled start", s, 32'h0080_0000);
        wr(TXW, 32'h22);
        wr(CTRL, 32'hD000_001F);
        wr(CTRL, 32'hD000_001F);
        wait_idle();
        rd(LVL, s);
        chk("R10 busy start ignored", s, 32'h0001_0001);
        rd(RXW, s);
        chk("R10 first word", s, 32'hFFFF_FFEE);
    endtask

    task automatic t_rxovf();
        logic [31:0] s;
        cleanup();
        for (int i = 0; i < 5; i++) xfer(32'h9000_0007, 32'(i + 1));
        rd(STAT, s);
        chk("R11 rx overflow", s, 32'h6260_0000);
        rd(RXW, s);
        chk("R11 oldest kept", s, 32'hFE);
        wr(STAT, 32'h0800_0000);
        rd(LVL, s);
        chk("R13 rx flush", s, 32'h0);
    endtask

    task automatic t_txunr();
        logic [31:0] s;
        cleanup();
        wr(CTRL, 32'hD000_0007);
        wait_idle();
        rd(STAT, s);
        chk("R12 tx underrun", s, 32'h6120_0000);
        rd(RXW, s);
        chk("R12 zeros shifted", s, 32'hFF);
    endtask

    task automatic t_enables();
        logic [31:0] s;
        cleanup();
        wr(CTRL2, 32'h4000_0000);
        xfer(32'h9000_0007, 32'h0F);
        rd(LVL, s);
        chk("R14 rx disabled", s, 32'h0);
        wr(CTRL2, 32'h8000_0000);
        xfer(32'h9000_0007, 32'h0F);
        rd(LVL, s);
        chk("R14 tx disabled no pop", s, 32'h0001_0001);
        rd(RXW, s);
        chk("R14 tx disabled zeros", s, 32'hFF);
    endtask

    initial begin
        #(8 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_len();
        t_modes();
        t_softcs();
        t_hwcs();
        t_txovf();
        t_rxunr();
        t_ignore();
        t_rxovf();
        t_txunr();
        t_enables();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule